// File: doc/BRIEF.md
# Asynchronous Exception Pending Controller

This block gathers the exception sources of a small processor core that are not tied to a specific instruction. These are extended-overflow events, parity faults on memory accesses and interrupt requests. Each source has a sticky pending bit. The block decides which pending condition may trap now and presents a single trap request with a vector code. The request is held until the core acknowledges it.

Parity checking is enabled per memory area. A parity event counts only if the area it names has its check enabled at the moment of the event. Once a condition is latched, it survives masking by the lock flag and blocking by a higher-priority condition. The only thing that clears it is taking its trap.

Taking any trap sets the lock flag. Taking an interrupt trap also sets the interrupt-mode flag. A return-from-exception input reloads both flags from a saved status copy supplied on input ports.

Top module: `async_exc_ctrl`

## Requirements
- R1: After synchronous reset, no condition is pending, `trap_req` is 0, `trap_vec` is 0, and `lock_flag` and `imode_flag` are 0.
- R2: A `par_evt` pulse latches a parity condition only if `par_en[par_area]` is 1. The trap is then presented with `trap_vec` = 1 from the cycle after the event. A parity event on a disabled area changes nothing.
- R3: A parity condition that arrives while `lock_flag` is 1 stays pending without a request. It is presented in the cycle after the lock is released.
- R4: After a condition is latched, clearing its enable bit in `par_en` does not remove it.
- R5: Any number of overflow events that arrive before the overflow trap is acknowledged merge into one pending condition and produce one trap, with `trap_vec` = 2.
- R6: An interrupt condition is latched by a pulse on any of `irq_ext`, `irq_timer` or `irq_io`, and is presented with `trap_vec` = 3.
- R7: When several conditions are presentable at once, the order is parity first, then overflow, then interrupt. Only one is presented at a time, and `trap_vec` is 0 when nothing is requested.
- R8: While `lock_flag` is 1, parity and interrupt conditions are masked, and a pending overflow condition is still presented.
- R9: `trap_req` stays 1 until `trap_ack`. An acknowledge clears only the presented condition. If an event of the same kind arrives in the acknowledge cycle, the condition stays pending. `trap_ack` while `trap_req` is 0 is ignored.
- R10: An acknowledged trap sets `lock_flag` to 1 at the next edge. An acknowledged interrupt trap also sets `imode_flag` to 1. Other traps leave `imode_flag` unchanged.
- R11: `rfe` loads `lock_flag` from `saved_lock` and `imode_flag` from `saved_imode`. If an acknowledged trap falls in the same cycle, the trap-entry update applies instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_evt | input | 1 | Extended-overflow event pulse |
| par_evt | input | 1 | Parity fault pulse for an access |
| par_area | input | 2 | Memory area of the faulting access |
| par_en | input | 4 | Per-area parity check enables |
| irq_ext | input | 1 | External interrupt request pulse |
| irq_timer | input | 1 | Timer interrupt request pulse |
| irq_io | input | 1 | I/O control-mode interrupt request pulse |
| trap_ack | input | 1 | Core accepts the presented trap |
| rfe | input | 1 | Return from exception: restore flags |
| saved_lock | input | 1 | Saved lock flag value |
| saved_imode | input | 1 | Saved interrupt-mode flag value |
| trap_req | output | 1 | A trap is presented |
| trap_vec | output | 2 | Vector code: 0 none, 1 parity, 2 overflow, 3 interrupt |
| lock_flag | output | 1 | Current lock flag |
| imode_flag | output | 1 | Current interrupt-mode flag |

## Verification
An event is sampled at one rising edge and latched by its pending register at that edge. `trap_req` and `trap_vec` are derived combinationally from those registers, so the request is due right after that edge. The same holds for the effect of an acknowledge or of a lock change caused by `rfe`: both appear one edge after the input is sampled, as do the flag updates.

The bench drives inputs at the falling edge. At the following rising edge it advances a behavioural model, and at the next falling edge it compares all four outputs with the model. Every result is therefore checked exactly one edge after its cause. Directed scenarios tag each comparison with the requirement under test, and a pseudo-random phase follows them.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
    localparam int NUM_SRC = 3;
    localparam int SRC_PAR = 0;
    localparam int SRC_OVF = 1;
    localparam int SRC_IRQ = 2;

    // sources that the lock flag masks
    localparam logic [NUM_SRC-1:0] LOCK_MASKED = 3'b101;

    typedef enum logic [1:0] {
        VEC_NONE   = 2'd0,
        VEC_PARITY = 2'd1,
        VEC_XOVF   = 2'd2,
        VEC_IRQ    = 2'd3
    } trap_vec_e;

    typedef struct packed {
        logic lock;
        logic imode;
    } core_flags_t;

    function automatic trap_vec_e vec_of(input int idx);
        case (idx)
            SRC_PAR: return VEC_PARITY;
            SRC_OVF: return VEC_XOVF;
            SRC_IRQ: return VEC_IRQ;
            default: return VEC_NONE;
        endcase
    endfunction
endpackage

// File: rtl/exc_pend_cell.sv
`timescale 1ns/1ps
module exc_pend_cell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        q && !clr |=> q);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
endmodule

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
    import exc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend,
    input  logic               lock,
    output logic [NUM_SRC-1:0] grant,
    output logic               req,
    output trap_vec_e          vec
);
    logic [NUM_SRC-1:0] avail;

    always_comb begin
        avail = pend & ~(LOCK_MASKED & {NUM_SRC{lock}});
        grant = '0;
        vec   = VEC_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (avail[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vec      = vec_of(i);
            end
        end
        req = |avail;
    end

    assert_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    assert_mask_R8: assert property (@(posedge clk) disable iff (rst)
        lock && req |-> vec == VEC_XOVF);
    assert_none_R7: assert property (@(posedge clk) disable iff (rst)
        !req |-> vec == VEC_NONE);
endmodule

// File: rtl/exc_flags.sv
`timescale 1ns/1ps
module exc_flags
    import exc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic        take_irq,
    input  logic        rfe,
    input  core_flags_t saved,
    output core_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (take) begin
            flags.lock <= 1'b1;
            if (take_irq) flags.imode <= 1'b1;
        end else if (rfe) begin
            flags <= saved;
        end
    end

    assert_lock_on_take_R10: assert property (@(posedge clk) disable iff (rst)
        take |=> flags.lock);
    assert_imode_on_irq_R10: assert property (@(posedge clk) disable iff (rst)
        take && take_irq |=> flags.imode);
    assert_restore_R11: assert property (@(posedge clk) disable iff (rst)
        rfe && !take |=> flags == $past(saved));
endmodule

// File: rtl/async_exc_ctrl.sv
`timescale 1ns/1ps
module async_exc_ctrl
    import exc_pkg::*;
#(
    parameter int NUM_AREAS = 4,
    localparam int AREA_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ovf_evt,
    input  logic                 par_evt,
    input  logic [AREA_W-1:0]    par_area,
    input  logic [NUM_AREAS-1:0] par_en,
    input  logic                 irq_ext,
    input  logic                 irq_timer,
    input  logic                 irq_io,
    input  logic                 trap_ack,
    input  logic                 rfe,
    input  logic                 saved_lock,
    input  logic                 saved_imode,
    output logic                 trap_req,
    output logic [1:0]           trap_vec,
    output logic                 lock_flag,
    output logic                 imode_flag
);
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] grant;
    logic               take;
    trap_vec_e          vec;
    core_flags_t        flags;
    core_flags_t        saved;

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_PAR] = par_evt && par_en[par_area];
        set_vec[SRC_OVF] = ovf_evt;
        set_vec[SRC_IRQ] = irq_ext | irq_timer | irq_io;
    end

    assign take = trap_ack && trap_req;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
        exc_pend_cell u_cell (
            .clk (clk),
            .rst (rst),
            .set (set_vec[g]),
            .clr (take && grant[g]),
            .q   (pend_vec[g])
        );
    end

    exc_arbiter u_arb (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend_vec),
        .lock  (flags.lock),
        .grant (grant),
        .req   (trap_req),
        .vec   (vec)
    );

    assign saved = '{lock: saved_lock, imode: saved_imode};

    exc_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .take_irq (grant[SRC_IRQ]),
        .rfe      (rfe),
        .saved    (saved),
        .flags    (flags)
    );

    assign trap_vec   = vec;
    assign lock_flag  = flags.lock;
    assign imode_flag = flags.imode;

    assert_par_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        par_evt && !par_en[par_area] && !pend_vec[SRC_PAR] |=> !pend_vec[SRC_PAR]);
    assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
        trap_req && !trap_ack && !rfe |=> trap_req);
    assert_par_first_R7: assert property (@(posedge clk) disable iff (rst)
        pend_vec[SRC_PAR] && !lock_flag |-> trap_vec == VEC_PARITY);
endmodule

// File: tb/test_async_exc_ctrl.sv
`timescale 1ns/1ps
module test_async_exc_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ovf_evt = 0, par_evt = 0, irq_ext = 0, irq_timer = 0, irq_io = 0;
    logic [1:0] par_area = 0;
    logic [3:0] par_en = 0;
    logic       trap_ack = 0, rfe = 0, saved_lock = 0, saved_imode = 0;
    logic       trap_req, lock_flag, imode_flag;
    logic [1:0] trap_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural model state
    bit m_par, m_ovf, m_irq, m_lock, m_imode;

    always #2.5 clk = ~clk;

    async_exc_ctrl i_async_exc_ctrl (
        .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .par_evt(par_evt),
        .par_area(par_area), .par_en(par_en), .irq_ext(irq_ext),
        .irq_timer(irq_timer), .irq_io(irq_io), .trap_ack(trap_ack),
        .rfe(rfe), .saved_lock(saved_lock), .saved_imode(saved_imode),
        .trap_req(trap_req), .trap_vec(trap_vec),
        .lock_flag(lock_flag), .imode_flag(imode_flag)
    );

    function automatic int model_vec();
        if (m_par && !m_lock) return 1;
        if (m_ovf) return 2;
        if (m_irq && !m_lock) return 3;
        return 0;
    endfunction

    task automatic model_step();
        int  v;
        bit  s_par, s_ovf, s_irq, took;
        if (rst) begin
            {m_par, m_ovf, m_irq, m_lock, m_imode} = '0;
            return;
        end
        v     = model_vec();
        took  = trap_ack && (v != 0);
        s_par = par_evt && par_en[par_area];
        s_ovf = ovf_evt;
        s_irq = irq_ext || irq_timer || irq_io;
        if (took && v == 1) m_par = 0;
        if (took && v == 2) m_ovf = 0;
        if (took && v == 3) m_irq = 0;
        if (s_par) m_par = 1;
        if (s_ovf) m_ovf = 1;
        if (s_irq) m_irq = 1;
        if (took) begin
            m_lock = 1;
            if (v == 3) m_imode = 1;
        end else if (rfe) begin
            m_lock  = saved_lock;
            m_imode = saved_imode;
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: model advances at the rising edge, outputs compared at the falling edge
    task automatic cyc(input string tag);
        int v;
        @(posedge clk);
        model_step();
        @(negedge clk);
        v = model_vec();
        check(tag, "trap_req", int'(trap_req), int'(v != 0));
        check(tag, "trap_vec", int'(trap_vec), v);
        check(tag, "lock_flag", int'(lock_flag), int'(m_lock));
        check(tag, "imode_flag", int'(imode_flag), int'(m_imode));
        {ovf_evt, par_evt, irq_ext, irq_timer, irq_io, trap_ack, rfe} = '0;
    endtask

    task automatic release_lock(input string tag);
        rfe = 1; saved_lock = 0; saved_imode = 0;
        cyc(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        rst = 1;
        cyc("R1"); cyc("R1");
        rst = 0;
        cyc("R1");
        // R2: disabled area ignored, enabled area latched
        par_en = 4'b1011; par_evt = 1; par_area = 2; cyc("R2"); cyc("R2");
        par_en = 4'b0100; par_evt = 1; par_area = 2; cyc("R2");
        cyc("R9"); cyc("R9");
        trap_ack = 1; cyc("R10");
        trap_ack = 1; cyc("R9");       // ack with nothing requested is ignored
        // R3/R4: blocked by lock, kept after enable cleared
        par_en = 4'b0001; par_area = 0; par_evt = 1; cyc("R3");
        par_en = 4'b0000; cyc("R4"); cyc("R4");
        release_lock("R3"); cyc("R3");
        trap_ack = 1; cyc("R9");
        release_lock("R11");
        // R5: overflow merge
        ovf_evt = 1; cyc("R5"); ovf_evt = 1; cyc("R5"); ovf_evt = 1; cyc("R5");
        trap_ack = 1; cyc("R5"); cyc("R5");
        // R8: overflow not masked by lock
        ovf_evt = 1; irq_ext = 1; cyc("R8"); cyc("R8");
        trap_ack = 1; cyc("R8"); cyc("R8");
        release_lock("R6");
        trap_ack = 1; cyc("R10");      // interrupt taken, imode set
        release_lock("R11");
        irq_timer = 1; cyc("R6"); trap_ack = 1; cyc("R6"); release_lock("R6");
        irq_io = 1; cyc("R6"); trap_ack = 1; cyc("R6"); release_lock("R6");
        // R7: all at once
        par_en = 4'b1111; par_area = 3; par_evt = 1; ovf_evt = 1; irq_ext = 1; cyc("R7");
        trap_ack = 1; cyc("R7");
        trap_ack = 1; cyc("R8");
        release_lock("R7");
        trap_ack = 1; cyc("R7");
        release_lock("R7");
        // R9: event in the acknowledge cycle keeps the bit
        ovf_evt = 1; cyc("R9");
        trap_ack = 1; ovf_evt = 1; cyc("R9"); cyc("R9");
        trap_ack = 1; cyc("R9");
        // R11: rfe loses to a same-cycle trap; then restores saved values
        ovf_evt = 1; cyc("R11");
        trap_ack = 1; rfe = 1; saved_lock = 0; saved_imode = 0; cyc("R11");
        rfe = 1; saved_lock = 1; saved_imode = 1; cyc("R11");
        rfe = 1; saved_lock = 0; saved_imode = 1; cyc("R11");
        release_lock("R11");
        // mixed random phase
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ovf_evt   = (lfsr[2:0] == 0);
            par_evt   = (lfsr[5:3] == 1);
            par_area  = lfsr[7:6];
            par_en    = lfsr[11:8];
            irq_ext   = (lfsr[14:12] == 2);
            irq_timer = (lfsr[4:2] == 5);
            irq_io    = (lfsr[9:7] == 6);
            trap_ack  = lfsr[1] | lfsr[9];
            rfe       = (lfsr[3:1] == 3);
            saved_lock  = lfsr[13];
            saved_imode = lfsr[15];
            cyc("R7");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule